// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit down-counter channel of a classic interval timer, reached over an 8-bit register bus. The bus exposes three registers: a data port, a write-only mode register and a system control/status register. A mode byte picks how the data port sequences bytes and how the counter behaves. It can also freeze the running count into a latch so that software reads a stable value. The control register gates the counter, routes the counter output to a speaker line, and reports the output level in a read-only status bit. Software polls that bit to see a one-shot delay expire.

Two counting behaviours are built. The first is a terminal-count mode: the output drops on a mode write or a load and rises once the loaded value has been counted out. The second is a square-wave mode that reloads itself, for driving a tone. Counting always uses binary. The counter advances only on cycles where the `tick` enable input is high, and `tick` is nominally pulsed at 1.193182 MHz from the system clock.

Top module: `pit_channel`

## Requirements
- R1: A mode byte is accepted only when bits 7:6 equal the channel parameter (default 2). Any other channel value leaves the block unchanged. Bits 5:4 hold the access code, bits 3:1 the operating code, and bit 0 (number format) is ignored, so counting is always binary.
- R2: Access code 3 loads the count with two data writes, low byte first and then high byte. Code 1 loads the low byte with the high byte zero. Code 2 loads the high byte with the low byte zero. The load is complete after the last byte.
- R3: A data read returns the low byte for code 1 and the high byte for code 2. For code 3 it returns the low byte and then the high byte on alternate reads.
- R4: A mode byte with access code 0 copies the current count into a latch. Data reads return the latched value until one full read sequence for the current access code has been made. A second latch command while a latch is held is ignored.
- R5: Terminal-count mode: a mode write or a completed load drives the output low. The first tick after the load copies the load value N into the count, and each later tick decrements it. The output goes high on the tick that brings the count to 0, which is N+1 ticks after the load. It stays high until the next mode write or load. N = 0 counts as 65536.
- R6: Square-wave mode: after a load of N, the output is low for floor(N/2) ticks and high for ceil(N/2) ticks, repeating without further writes. N = 0 counts as 65536, and a low phase of 0 is lengthened to 1 tick.
- R7: Operating codes 3 and 7 select square-wave mode. Every other code, including 6, behaves as terminal-count mode.
- R8: Control bit 0 is the gate. While it is 0, ticks are ignored and the count holds. In square-wave mode the output is also forced high, and counting restarts from a full reload on the first tick after the gate returns to 1.
- R9: Control bit 1 enables the speaker. When it is set, `spk_out` follows the counter output. When it is clear, `spk_out` is 0.
- R10: A control read returns the gate in bit 0, the speaker enable in bit 1 and the counter output level in bit 5 (1 once terminal-count mode expires), with all other bits 0. Written bits 7:2 are ignored. The mode register reads as 0.
- R11: The register addresses are 0 for the data port, 1 for the mode register and 2 for the control register. Address 3 is unused.
- R12: After reset, the gate, speaker enable, counter output and count are 0, the access code is 3 and the operating behaviour is terminal-count mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable, one pulse per count step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; advances the read byte sequence |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| cnt_out | output | 1 | Counter output level |
| spk_out | output | 1 | Speaker line |

## Verification
The bench builds the block with its default channel parameter of 2, so mode bytes 0xB0, 0xB6 and 0x80 address it. Channel fields 0 and 3 then serve as foreign writes that must change nothing. The counter keeps its fixed 16-bit width, which puts the 65536-tick load of zero within the run length, together with the one-tick and two-tick loads at the short end. Mode-3 phase lengths are measured tick by tick for even and odd reload values.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;

    // access code in mode byte bits 5:4
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_e;

    // register addresses
    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_MODE = 2'd1,
        ADR_CTRL = 2'd2,
        ADR_NONE = 2'd3
    } adr_e;

    // control register bit positions
    localparam int CTL_GATE = 0;
    localparam int CTL_SPK  = 1;
    localparam int CTL_OUT  = 5;

endpackage

// File: rtl/pit_host_regs.sv
module pit_host_regs
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [CNT_W-1:0] count_i,
    input  logic             out_i,
    output logic             mode_wr_o,
    output logic             mode_sqw_o,
    output logic             load_o,
    output logic             hold_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             sqw_o,
    output logic             gate_o,
    output logic             spk_en_o
);

    typedef struct packed {
        logic             sqw;
        acc_e             acc;
        logic             wr_hi;
        logic             rd_hi;
        logic             latch_v;
        logic [CNT_W-1:0] latch;
        logic [CNT_W-1:0] reload;
        logic             gate;
        logic             spk_en;
    } host_t;

    host_t q, d;

    logic             sel_mode;
    acc_e             acc_new;
    logic [2:0]       op_new;
    logic [CNT_W-1:0] rd_src;
    logic             rd_pick_hi;
    adr_e             adr;

    always_comb begin
        d          = q;
        mode_wr_o  = 1'b0;
        mode_sqw_o = 1'b0;
        load_o     = 1'b0;
        hold_o     = 1'b0;
        rdata      = '0;
        adr        = adr_e'(addr);
        acc_new    = acc_e'(wdata[5:4]);
        op_new     = wdata[3:1];
        sel_mode   = wr_en && (adr == ADR_MODE) && (wdata[7:6] == CHAN_ID);
        rd_src     = q.latch_v ? q.latch : count_i;
        rd_pick_hi = (q.acc == ACC_HI) || ((q.acc == ACC_BOTH) && q.rd_hi);

        // read data path
        case (adr)
            ADR_DATA: rdata = rd_pick_hi ? rd_src[CNT_W-1:BUS_W] : rd_src[BUS_W-1:0];
            ADR_CTRL: begin
                rdata[CTL_GATE] = q.gate;
                rdata[CTL_SPK]  = q.spk_en;
                rdata[CTL_OUT]  = out_i;
            end
            default:  rdata = '0;
        endcase

        // mode register
        if (sel_mode) begin
            if (acc_new == ACC_LATCH) begin
                if (!q.latch_v) begin
                    d.latch_v = 1'b1;
                    d.latch   = count_i;
                    d.rd_hi   = 1'b0;
                end
            end else begin
                d.acc      = acc_new;
                d.sqw      = &op_new[1:0];
                d.wr_hi    = 1'b0;
                d.rd_hi    = 1'b0;
                d.latch_v  = 1'b0;
                mode_wr_o  = 1'b1;
                mode_sqw_o = &op_new[1:0];
            end
        end

        // data port write
        if (wr_en && (adr == ADR_DATA)) begin
            case (q.acc)
                ACC_LO: begin
                    d.reload = {{BUS_W{1'b0}}, wdata};
                    load_o   = 1'b1;
                end
                ACC_HI: begin
                    d.reload = {wdata, {BUS_W{1'b0}}};
                    load_o   = 1'b1;
                end
                ACC_BOTH: begin
                    if (!q.wr_hi) begin
                        d.reload[BUS_W-1:0] = wdata;
                        d.wr_hi             = 1'b1;
                        hold_o              = 1'b1;
                    end else begin
                        d.reload[CNT_W-1:BUS_W] = wdata;
                        d.wr_hi                 = 1'b0;
                        load_o                  = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // control register write
        if (wr_en && (adr == ADR_CTRL)) begin
            d.gate   = wdata[CTL_GATE];
            d.spk_en = wdata[CTL_SPK];
        end

        // data port read sequencing
        if (rd_en && (adr == ADR_DATA)) begin
            case (q.acc)
                ACC_BOTH: begin
                    if (!q.rd_hi) begin
                        d.rd_hi = 1'b1;
                    end else begin
                        d.rd_hi   = 1'b0;
                        d.latch_v = 1'b0;
                    end
                end
                default: d.latch_v = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sqw: 1'b0, acc: ACC_BOTH, wr_hi: 1'b0, rd_hi: 1'b0, latch_v: 1'b0,
                   latch: '0, reload: '0, gate: 1'b0, spk_en: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign reload_o = q.reload;
    assign sqw_o    = q.sqw;
    assign gate_o   = q.gate;
    assign spk_en_o = q.spk_en;

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             sqw,
    input  logic             mode_wr,
    input  logic             mode_sqw,
    input  logic             load,
    input  logic             hold,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);

    localparam logic [CNT_W-1:0] HALF_FULL = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             out;
        logic             pend;
        logic             run;
    } core_t;

    core_t q, d;

    logic [CNT_W-1:0] half_hi;
    logic [CNT_W-1:0] half_lo;

    // phase lengths of the square wave; a zero reload stands for 2**CNT_W
    always_comb begin
        if (reload == '0) begin
            half_hi = HALF_FULL;
            half_lo = HALF_FULL;
        end else begin
            half_hi = (reload >> 1) + {{(CNT_W-1){1'b0}}, reload[0]};
            half_lo = reload >> 1;
            if (half_lo == '0) begin
                half_lo = ONE;
            end
        end
    end

    always_comb begin
        d = q;
        if (mode_wr) begin
            d.run  = 1'b0;
            d.pend = 1'b0;
            d.out  = mode_sqw;
        end else if (load) begin
            d.pend = 1'b1;
            d.run  = 1'b0;
            d.out  = sqw;
        end else if (hold && !sqw) begin
            d.run = 1'b0;
        end else if (sqw && !gate) begin
            d.out = 1'b1;
            if (q.run) begin
                d.pend = 1'b1;
                d.run  = 1'b0;
            end
        end else if (tick && gate) begin
            if (q.pend) begin
                d.pend  = 1'b0;
                d.run   = 1'b1;
                d.count = sqw ? half_hi : reload;
                if (sqw) begin
                    d.out = 1'b1;
                end
            end else if (q.run) begin
                if (sqw) begin
                    if (q.count == ONE) begin
                        d.out   = ~q.out;
                        d.count = q.out ? half_lo : half_hi;
                    end else begin
                        d.count = q.count - ONE;
                    end
                end else begin
                    d.count = q.count - ONE;
                    if (q.count == ONE) begin
                        d.out = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_o = q.count;
    assign out_o   = q.out;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             cnt_out,
    output logic             spk_out
);

    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] reload_w;
    logic             out_w;
    logic             mode_wr_w;
    logic             mode_sqw_w;
    logic             load_w;
    logic             hold_w;
    logic             sqw_w;
    logic             gate_w;
    logic             spk_en_w;

    pit_host_regs #(
        .CHAN_ID (CHAN_ID)
    ) i_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .count_i    (count_w),
        .out_i      (out_w),
        .mode_wr_o  (mode_wr_w),
        .mode_sqw_o (mode_sqw_w),
        .load_o     (load_w),
        .hold_o     (hold_w),
        .reload_o   (reload_w),
        .sqw_o      (sqw_w),
        .gate_o     (gate_w),
        .spk_en_o   (spk_en_w)
    );

    pit_count_core i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate_w),
        .sqw      (sqw_w),
        .mode_wr  (mode_wr_w),
        .mode_sqw (mode_sqw_w),
        .load     (load_w),
        .hold     (hold_w),
        .reload   (reload_w),
        .count_o  (count_w),
        .out_o    (out_w)
    );

    assign cnt_out = out_w;
    assign spk_out = spk_en_w & out_w;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [BUS_W-1:0] wdata,
    input logic             cnt_out,
    input logic             spk_out,
    input logic             gate,
    input logic             sqw,
    input logic [CNT_W-1:0] count,
    input logic             mode_wr,
    input logic             load
);

    // R1: a mode byte for another channel raises no mode write
    a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata[7:6] != CHAN_ID) |-> !mode_wr);

    // R5: a terminal-count mode write drives the output low
    a_r5_mode_write_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata[7:6] == CHAN_ID && wdata[5:4] != 2'd0
         && wdata[2:1] != 2'b11) |=> !cnt_out);

    // R5: once high in terminal-count mode, the output stays high until a write
    a_r5_sticky_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw && cnt_out && !mode_wr && !load) |=> cnt_out);

    // R8: a closed gate freezes the count
    a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> $stable(count));

    // R8: a closed gate forces the square-wave output high
    a_r8_sqw_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sqw && !gate && !mode_wr) |=> cnt_out);

    // R9: the speaker is never active while the counter output is low
    a_r9_speaker_follows: assert property (@(posedge clk) disable iff (!rst_n)
        spk_out |-> cnt_out);

endmodule

bind pit_channel pit_channel_chk #(
    .CHAN_ID (CHAN_ID)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt_out (cnt_out),
    .spk_out (spk_out),
    .gate    (gate_w),
    .sqw     (sqw_w),
    .count   (count_w),
    .mode_wr (mode_wr_w),
    .load    (load_w)
);

// File: tb/test_pit_channel.sv
module test_pit_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cnt_out;
    logic       spk_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    pit_channel i_pit_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .cnt_out (cnt_out),
        .spk_out (spk_out)
    );

    // terminal-count vectors: {load value, ticks until output rises}
    localparam logic [31:0] MODE0_VEC [4] = '{
        {16'd1,   16'd2},
        {16'd2,   16'd3},
        {16'd7,   16'd8},
        {16'd300, 16'd301}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1;
        addr  = a;
        #1;
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        bus_wr(2'd0, v[7:0]);
        bus_wr(2'd0, v[15:8]);
    endtask

    // measure one low phase and the following high phase, in ticks
    task automatic sq_measure(output int lo_len, output int hi_len);
        int n;
        n = 0;
        while (cnt_out == 1'b1 && n < 70000) begin
            run_ticks(1);
            n++;
        end
        lo_len = 0;
        while (cnt_out == 1'b0 && lo_len < 70000) begin
            run_ticks(1);
            lo_len++;
        end
        hi_len = 0;
        while (cnt_out == 1'b1 && hi_len < 70000) begin
            run_ticks(1);
            hi_len++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb, rb2;
        int lo_len, hi_len;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12 cnt_out after reset", cnt_out, 0);
        check("R12 spk_out after reset", spk_out, 0);
        bus_rd(2'd2, rb);
        check("R12 control after reset", rb, 8'h00);
        bus_rd(2'd0, rb);
        check("R12 count low byte after reset", rb, 8'h00);
        bus_rd(2'd1, rb);
        check("R10 mode register reads zero", rb, 8'h00);

        // R11 gate on through control address
        bus_wr(2'd2, 8'h01);
        bus_rd(2'd2, rb);
        check("R11 control register at address 2", rb, 8'h01);

        // R5 terminal-count vectors
        foreach (MODE0_VEC[k]) begin
            bus_wr(2'd1, 8'hB0);
            check("R5 mode write drives output low", cnt_out, 0);
            load16(MODE0_VEC[k][31:16]);
            run_ticks(int'(MODE0_VEC[k][15:0]) - 1);
            check("R5 output still low one tick before expiry", cnt_out, 0);
            run_ticks(1);
            check("R5 output high at expiry", cnt_out, 1);
            bus_rd(2'd2, rb);
            check("R10 status bit set on expiry", rb, 8'h21);
        end

        run_ticks(5);
        check("R5 output stays high after expiry", cnt_out, 1);

        // R1 foreign channel bytes
        bus_wr(2'd1, 8'h30);
        check("R1 channel 0 mode byte ignored", cnt_out, 1);
        bus_wr(2'd1, 8'hF0);
        check("R1 channel 3 mode byte ignored", cnt_out, 1);

        // R5 zero load means 65536
        bus_wr(2'd1, 8'hB0);
        load16(16'h0000);
        run_ticks(65536);
        check("R5 zero load not expired at 65536 ticks", cnt_out, 0);
        run_ticks(1);
        check("R5 zero load expired at 65537 ticks", cnt_out, 1);

        // R3 / R4 reads and latch
        bus_wr(2'd1, 8'hB0);
        load16(16'd1000);
        run_ticks(10);
        bus_wr(2'd1, 8'h80);
        run_ticks(5);
        bus_rd(2'd0, rb);
        bus_rd(2'd0, rb2);
        check("R4 latched value", {rb2, rb}, 991);
        bus_rd(2'd0, rb);
        bus_rd(2'd0, rb2);
        check("R3 live read low then high", {rb2, rb}, 986);
        bus_wr(2'd1, 8'h80);
        run_ticks(3);
        bus_wr(2'd1, 8'h80);
        run_ticks(1);
        bus_rd(2'd0, rb);
        bus_rd(2'd0, rb2);
        check("R4 second latch command ignored", {rb2, rb}, 986);

        // R2 / R3 low byte only
        bus_wr(2'd1, 8'h90);
        bus_wr(2'd0, 8'h05);
        run_ticks(1);
        bus_rd(2'd0, rb);
        check("R3 low-only access reads low byte", rb, 8'h05);
        run_ticks(4);
        check("R2 low-only load not yet expired", cnt_out, 0);
        run_ticks(1);
        check("R2 low-only load expires after 6 ticks", cnt_out, 1);

        // R2 / R3 high byte only
        bus_wr(2'd1, 8'hA0);
        bus_wr(2'd0, 8'h01);
        run_ticks(1);
        bus_rd(2'd0, rb);
        check("R3 high-only access reads high byte", rb, 8'h01);
        run_ticks(255);
        check("R2 high-only load not yet expired", cnt_out, 0);
        run_ticks(1);
        check("R2 high-only load expires after 257 ticks", cnt_out, 1);

        // R8 gate hold in terminal-count mode
        bus_wr(2'd1, 8'hB0);
        load16(16'd500);
        run_ticks(1);
        bus_wr(2'd2, 8'h00);
        run_ticks(20);
        bus_wr(2'd2, 8'h01);
        bus_wr(2'd1, 8'h80);
        bus_rd(2'd0, rb);
        bus_rd(2'd0, rb2);
        check("R8 closed gate holds count", {rb2, rb}, 500);

        // R9 speaker
        bus_wr(2'd2, 8'h03);
        check("R9 speaker low while output low", spk_out, 0);
        run_ticks(500);
        check("R9 speaker follows high output", spk_out, 1);
        bus_wr(2'd2, 8'h01);
        check("R9 speaker off when disabled", spk_out, 0);

        // R10 write mask on control
        bus_wr(2'd2, 8'hFD);
        bus_rd(2'd2, rb);
        check("R10 control upper write bits ignored", rb, 8'h21);
        bus_wr(2'd2, 8'h01);

        // R6 square wave
        bus_wr(2'd1, 8'hB6);
        check("R6 square-wave mode write drives output high", cnt_out, 1);
        load16(16'd6);
        sq_measure(lo_len, hi_len);
        check("R6 even reload low phase", lo_len, 3);
        check("R6 even reload high phase", hi_len, 3);
        load16(16'd5);
        sq_measure(lo_len, hi_len);
        check("R6 odd reload low phase", lo_len, 2);
        check("R6 odd reload high phase", hi_len, 3);

        // R7 operating code 7 and 6
        bus_wr(2'd1, 8'hBE);
        load16(16'd4);
        sq_measure(lo_len, hi_len);
        check("R7 code 7 low phase", lo_len, 2);
        check("R7 code 7 high phase", hi_len, 2);
        bus_wr(2'd1, 8'hBC);
        check("R7 code 6 behaves as terminal count", cnt_out, 0);
        load16(16'd3);
        run_ticks(3);
        check("R7 code 6 not yet expired", cnt_out, 0);
        run_ticks(1);
        check("R7 code 6 expires after 4 ticks", cnt_out, 1);

        // R8 gate forces square wave high and restarts
        bus_wr(2'd1, 8'hB6);
        load16(16'd8);
        for (int i = 0; i < 20 && cnt_out == 1'b1; i++) begin
            run_ticks(1);
        end
        check("R8 square wave in low phase", cnt_out, 0);
        bus_wr(2'd2, 8'h00);
        @(negedge clk);
        check("R8 closed gate forces output high", cnt_out, 1);
        bus_wr(2'd2, 8'h01);
        sq_measure(lo_len, hi_len);
        check("R8 restart low phase after gate", lo_len, 4);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule